// File: doc/BRIEF.md
# Read Strobe Leveling Sweep Engine

This block calibrates the read strobe delay of every byte lane of a DDR3 data path. On a start pulse it sends a mode register write that switches the memory to its fixed training pattern. It then steps a strobe delay code upward from zero. After each step it waits a set number of settle cycles, issues one read, and compares each lane's sampled byte with the byte that the pattern should give on the chosen strobe edge.

Each lane keeps its lowest and highest passing codes on its own. When the sweep reaches its last code, the engine writes the mode register back to normal operation. Each lane then receives the midpoint of its pass range as its delay code. A lane that never passed raises its error flag and takes a default code.

The delay line and the PHY lie outside the block. They see the delay code outputs, and they answer the command port and the response inputs.

Top module: `rdlvl_sweep`

## Requirements
- R1: After a start pulse is accepted in idle, the first command is a mode register write with select 3 (`cmd_mr_sel_o`=3, `cmd_is_read_o`=0) and value 0x0004, and no read comes before it.
- R2: After the last read, the engine issues one more mode register write with select 3 and value 0x0000, and it does so before `done_o` rises. A calibration issues exactly two mode register writes.
- R3: `edge_fall_i` is sampled at start. When it is 0 the expected byte is 0x00, and when it is 1 the expected byte is 0xFF. Changes to it during a sweep have no effect.
- R4: A step passes for a lane only when all 8 bits of that lane's byte (`resp_data_i[8*lane +: 8]`) equal the expected byte. A single differing bit fails the step.
- R5: The sweep code starts at 0 and rises by 1 per step up to MAX_CODE, with exactly one read per code. During the sweep, every lane's `dly_code_o` field (`[CODE_W*lane +: CODE_W]`) shows the current code.
- R6: Each lane is evaluated on its own. Its final code is (lowest passing code + highest passing code) >> 1, truncated.
- R7: A lane with no passing code ends with its `lane_err_o` bit at 1 and its code at DEF_CODE. A lane that passed at least once ends with its error bit at 0.
- R8: After every change of the sweep code, at least SETTLE_CYC cycles pass before the next read request.
- R9: A command request holds its kind and value unchanged until `cmd_ack_i` accepts it. After an accepted read, the engine waits for `resp_valid_i` before it steps.
- R10: `done_o` is high for exactly one cycle per calibration. A start pulse during a sweep is ignored. The final codes and flags stay unchanged after done until the next start.
- R11: After reset, `done_o` and `cmd_req_o` are 0, every lane code is DEF_CODE and every error flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only in idle |
| edge_fall_i | input | 1 | Strobe edge to check: 0 rising (expect 0x00), 1 falling (expect 0xFF) |
| done_o | output | 1 | One-cycle completion pulse |
| cmd_req_o | output | 1 | Command request, held until acknowledged |
| cmd_ack_i | input | 1 | Command accepted on this clock edge |
| cmd_is_read_o | output | 1 | 1 for a read, 0 for a mode register write |
| cmd_mr_sel_o | output | 2 | Mode register select (3 for writes, 0 for reads) |
| cmd_mr_val_o | output | 16 | Mode register write value |
| resp_valid_i | input | 1 | Read response valid |
| resp_data_i | input | LANES*8 | Sampled byte per lane, lane n at bits 8n+7:8n |
| dly_code_o | output | LANES*CODE_W | Strobe delay code per lane |
| lane_err_o | output | LANES | Per-lane no-pass flag |

## Verification
The assertions assume that the environment acknowledges each request at some point, and that it raises `resp_valid_i` only while a read is outstanding. They also assume that the delay code stays steady from a read's acknowledge until its response. The bench's responder model acknowledges only requests it sees asserted, with a random delay of zero to two cycles. It answers each accepted read exactly once, with a byte built from the delay codes it observes at that time. Pass windows, isolated pass spikes and single-bit or multi-bit corruptions are drawn from a seeded generator. The bench also drives a start pulse and an edge toggle in the middle of a sweep.

// File: rtl/rdlvl_pkg.sv
package rdlvl_pkg;

  localparam int LANE_BITS = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_MR_ON, S_SETTLE, S_RD_REQ, S_RD_WAIT, S_STEP, S_MR_OFF, S_DONE
  } sweep_state_e;

  localparam logic [1:0]  MR_SEL_PATTERN = 2'd3;
  localparam logic [15:0] MR_VAL_PATTERN = 16'h0004;
  localparam logic [15:0] MR_VAL_NORMAL  = 16'h0000;

  // expected byte from the strobe edge: all zeros rising, all ones falling
  function automatic logic [LANE_BITS-1:0] expect_byte(input logic fall);
    return {LANE_BITS{fall}};
  endfunction

  // centre of a pass window, fraction dropped
  function automatic logic [15:0] mid_code(input logic [15:0] lo, input logic [15:0] hi);
    logic [16:0] sum;
    sum = {1'b0, lo} + {1'b0, hi};
    return sum[16:1];
  endfunction

endpackage

// File: rtl/rdlvl_settle_timer.sv
module rdlvl_settle_timer #(
  parameter int SETTLE_CYC = 4,
  parameter int CNT_W      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load_i)                  cnt_q <= LOAD_VAL;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R8
  settle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == LOAD_VAL);
endmodule

// File: rtl/rdlvl_seq.sv
module rdlvl_seq
  import rdlvl_pkg::*;
#(
  parameter int CODE_W   = 7,
  parameter int MAX_CODE = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ack_i,
  input  logic              resp_valid_i,
  input  logic              settle_done_i,
  output logic [CODE_W-1:0] code_o,
  output logic              sweeping_o,
  output logic              clear_o,
  output logic              sample_o,
  output logic              commit_o,
  output logic              settle_load_o,
  output logic              settle_tick_o,
  output logic              done_o,
  output logic              cmd_req_o,
  output logic              cmd_is_read_o,
  output logic [1:0]        cmd_mr_sel_o,
  output logic [15:0]       cmd_mr_val_o
);
  localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(MAX_CODE);

  sweep_state_e      state_q, state_d;
  logic [CODE_W-1:0] code_q;
  logic              at_last;

  assign at_last = (code_q == LAST_CODE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (start_i)       state_d = S_MR_ON;
      S_MR_ON:   if (ack_i)         state_d = S_SETTLE;
      S_SETTLE:  if (settle_done_i) state_d = S_RD_REQ;
      S_RD_REQ:  if (ack_i)         state_d = S_RD_WAIT;
      S_RD_WAIT: if (resp_valid_i)  state_d = S_STEP;
      S_STEP:    state_d = at_last ? S_MR_OFF : S_SETTLE;
      S_MR_OFF:  if (ack_i)         state_d = S_DONE;
      S_DONE:    state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      if (clear_o)                        code_q <= '0;
      else if (state_q == S_STEP && !at_last) code_q <= code_q + 1'b1;
    end
  end

  assign code_o        = code_q;
  assign sweeping_o    = (state_q != S_IDLE) && (state_q != S_DONE);
  assign clear_o       = (state_q == S_IDLE) && start_i;
  assign sample_o      = (state_q == S_RD_WAIT) && resp_valid_i;
  assign commit_o      = (state_q == S_MR_OFF) && ack_i;
  assign settle_load_o = ((state_q == S_MR_ON) && ack_i) || ((state_q == S_STEP) && !at_last);
  assign settle_tick_o = (state_q == S_SETTLE);
  assign done_o        = (state_q == S_DONE);

  always_comb begin
    cmd_req_o     = 1'b0;
    cmd_is_read_o = 1'b0;
    cmd_mr_sel_o  = 2'd0;
    cmd_mr_val_o  = 16'h0000;
    unique case (state_q)
      S_MR_ON:  begin cmd_req_o = 1'b1; cmd_mr_sel_o = MR_SEL_PATTERN; cmd_mr_val_o = MR_VAL_PATTERN; end
      S_MR_OFF: begin cmd_req_o = 1'b1; cmd_mr_sel_o = MR_SEL_PATTERN; cmd_mr_val_o = MR_VAL_NORMAL; end
      S_RD_REQ: begin cmd_req_o = 1'b1; cmd_is_read_o = 1'b1; end
      default:  ;
    endcase
  end

  // R1
  pattern_on_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |=> cmd_req_o && !cmd_is_read_o && cmd_mr_val_o == MR_VAL_PATTERN);
  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req_o && !ack_i) |=> cmd_req_o && $stable(cmd_is_read_o) && $stable(cmd_mr_val_o));
  // R5
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && !at_last) |=> ##1 code_q == $past(code_q, 2) + 1'b1);
  // R5
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= LAST_CODE);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R2
  normal_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(cmd_req_o) && $past(cmd_mr_val_o) == MR_VAL_NORMAL);
endmodule

// File: rtl/rdlvl_lane_win.sv
module rdlvl_lane_win
  import rdlvl_pkg::*;
#(
  parameter int CODE_W   = 7,
  parameter int DEF_CODE = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 sample_i,
  input  logic                 commit_i,
  input  logic [CODE_W-1:0]    code_i,
  input  logic [LANE_BITS-1:0] resp_i,
  input  logic [LANE_BITS-1:0] expect_i,
  output logic                 hit_o,
  output logic [CODE_W-1:0]    final_o,
  output logic                 err_o
);
  localparam logic [CODE_W-1:0] DEF_VAL = CODE_W'(DEF_CODE);

  logic              found_q;
  logic [CODE_W-1:0] low_q, high_q, final_q;
  logic              err_q;
  logic [CODE_W-1:0] centre;

  assign hit_o  = (resp_i == expect_i);
  assign centre = CODE_W'(mid_code(16'(low_q), 16'(high_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q <= 1'b0;
      low_q   <= '0;
      high_q  <= '0;
      final_q <= DEF_VAL;
      err_q   <= 1'b0;
    end else if (clear_i) begin
      found_q <= 1'b0;
    end else if (sample_i && hit_o) begin
      if (!found_q) low_q <= code_i;
      high_q  <= code_i;
      found_q <= 1'b1;
    end else if (commit_i) begin
      final_q <= found_q ? centre : DEF_VAL;
      err_q   <= !found_q;
    end
  end

  assign final_o = final_q;
  assign err_o   = err_q;

  // R6
  win_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found_q |-> low_q <= high_q);
  // R6
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && found_q) |=> final_o >= $past(low_q) && final_o <= $past(high_q));
  // R7
  err_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> final_o == DEF_VAL);
endmodule

// File: rtl/rdlvl_sweep.sv
module rdlvl_sweep
  import rdlvl_pkg::*;
#(
  parameter int LANES      = 2,
  parameter int CODE_W     = 7,
  parameter int MAX_CODE   = 127,
  parameter int DEF_CODE   = 32,
  parameter int SETTLE_CYC = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic                      edge_fall_i,
  output logic                      done_o,
  output logic                      cmd_req_o,
  input  logic                      cmd_ack_i,
  output logic                      cmd_is_read_o,
  output logic [1:0]                cmd_mr_sel_o,
  output logic [15:0]               cmd_mr_val_o,
  input  logic                      resp_valid_i,
  input  logic [LANES*LANE_BITS-1:0] resp_data_i,
  output logic [LANES*CODE_W-1:0]   dly_code_o,
  output logic [LANES-1:0]          lane_err_o
);
  localparam int CNT_W = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);

  logic [CODE_W-1:0]    sweep_code;
  logic                 sweeping, clear_evt, sample_evt, commit_evt;
  logic                 settle_load, settle_tick, settle_done;
  logic                 edge_q;
  logic [LANE_BITS-1:0] expect_val;
  logic [LANES-1:0]     lane_hit;

  rdlvl_seq #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(cmd_ack_i),
    .resp_valid_i(resp_valid_i), .settle_done_i(settle_done),
    .code_o(sweep_code), .sweeping_o(sweeping), .clear_o(clear_evt),
    .sample_o(sample_evt), .commit_o(commit_evt),
    .settle_load_o(settle_load), .settle_tick_o(settle_tick), .done_o(done_o),
    .cmd_req_o(cmd_req_o), .cmd_is_read_o(cmd_is_read_o),
    .cmd_mr_sel_o(cmd_mr_sel_o), .cmd_mr_val_o(cmd_mr_val_o));

  rdlvl_settle_timer #(.SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .load_i(settle_load), .tick_i(settle_tick),
    .expired_o(settle_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         edge_q <= 1'b0;
    else if (clear_evt) edge_q <= edge_fall_i;
  end

  assign expect_val = expect_byte(edge_q);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CODE_W-1:0] lane_final;
    rdlvl_lane_win #(.CODE_W(CODE_W), .DEF_CODE(DEF_CODE)) u_win (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_evt), .sample_i(sample_evt),
      .commit_i(commit_evt), .code_i(sweep_code),
      .resp_i(resp_data_i[g*LANE_BITS +: LANE_BITS]), .expect_i(expect_val),
      .hit_o(lane_hit[g]), .final_o(lane_final), .err_o(lane_err_o[g]));
    assign dly_code_o[g*CODE_W +: CODE_W] = sweeping ? sweep_code : lane_final;
  end

  // cycles since the last code change, for the settle check
  logic [CNT_W:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_q <= '0;
    else if (settle_load)      since_q <= '0;
    else if (since_q != '1)    since_q <= since_q + 1'b1;
  end

  // R8
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_req_o && cmd_is_read_o) |-> since_q >= (CNT_W+1)'(SETTLE_CYC));
  // R3
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweeping && !clear_evt) |=> $stable(edge_q));
  // R4
  hit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_hit[0] |-> resp_data_i[LANE_BITS-1:0] == {LANE_BITS{edge_q}});
endmodule

// File: tb/rdlvl_sweep_test.sv
module rdlvl_sweep_test;
  localparam int LANES = 2, CODE_W = 7, MAX_CODE = 127, DEF_CODE = 32, SETTLE_CYC = 4;

  logic clk = 0, rst_n = 0, start_i = 0, edge_fall_i = 0;
  logic done_o, cmd_req_o, cmd_ack_i = 0, cmd_is_read_o, resp_valid_i = 0;
  logic [1:0] cmd_mr_sel_o;
  logic [15:0] cmd_mr_val_o;
  logic [LANES*8-1:0] resp_data_i = '0;
  logic [LANES*CODE_W-1:0] dly_code_o;
  logic [LANES-1:0] lane_err_o;

  int checks = 0, fails = 0;
  bit finished = 0;
  int lo[2], hi[2], spk[2];
  int since = 0, settle_bad = 0;
  logic [CODE_W-1:0] last_code = '0;
  bit prev_rd = 0;

  always #4 clk = ~clk;

  rdlvl_sweep #(.LANES(LANES), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE),
                .DEF_CODE(DEF_CODE), .SETTLE_CYC(SETTLE_CYC)) uut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit passes(int l, int c);
    return (c >= lo[l] && c <= hi[l]) || c == spk[l];
  endfunction

  function automatic int exp_low(int l);
    for (int c = 0; c <= MAX_CODE; c++) if (passes(l, c)) return c;
    return -1;
  endfunction

  function automatic int exp_high(int l);
    for (int c = MAX_CODE; c >= 0; c--) if (passes(l, c)) return c;
    return -1;
  endfunction

  function automatic int code_of(int l);
    return int'(dly_code_o[l*CODE_W +: CODE_W]);
  endfunction

  // settle monitor (observes only)
  always @(negedge clk) begin
    if (dly_code_o[CODE_W-1:0] != last_code) begin last_code = dly_code_o[CODE_W-1:0]; since = 0; end
    else since++;
    if (cmd_req_o && cmd_is_read_o && !prev_rd && since < SETTLE_CYC) settle_bad++;
    prev_rd = cmd_req_o && cmd_is_read_o;
  end

  task automatic run_cal(bit fall, bit disturb);
    int reads = 0, mrw = 0, first_mrw = -1, last_val = -1, first_sel = -1;
    int step_bad = 0, hold_bad = 0, read_before_mrw = 0, done_cycles = 0;
    bit disturbed = 0;
    settle_bad = 0;
    @(negedge clk); edge_fall_i = fall; start_i = 1;
    @(negedge clk); start_i = 0;
    while (!done_o) begin
      if (disturb && !disturbed && reads == 40) begin
        disturbed = 1; start_i = 1; edge_fall_i = ~fall;
        @(negedge clk); start_i = 0;
        continue;
      end
      if (cmd_req_o) begin
        bit rd = cmd_is_read_o;
        logic [15:0] v = cmd_mr_val_o;
        logic [1:0] s = cmd_mr_sel_o;
        int d = $urandom_range(0, 2);
        for (int k = 0; k < d; k++) begin
          @(negedge clk);
          if (!cmd_req_o || cmd_is_read_o != rd || cmd_mr_val_o != v) hold_bad++;
        end
        if (rd) begin
          if (mrw == 0) read_before_mrw++;
          if (code_of(0) != reads || code_of(1) != reads) step_bad++;
          reads++;
        end else begin
          if (mrw == 0) begin first_mrw = v; first_sel = s; end
          last_val = v; mrw++;
        end
        cmd_ack_i = 1;
        @(negedge clk); cmd_ack_i = 0;
        if (rd) begin
          d = $urandom_range(0, 2);
          repeat (d) @(negedge clk);
          for (int l = 0; l < LANES; l++) begin
            logic [7:0] e = {8{fall}};
            logic [7:0] m = ($urandom_range(0, 1) == 1) ? 8'(1 << $urandom_range(0, 7))
                                                        : 8'($urandom_range(1, 255));
            resp_data_i[l*8 +: 8] = passes(l, code_of(l)) ? e : (e ^ m);
          end
          resp_valid_i = 1;
          @(negedge clk); resp_valid_i = 0;
        end
      end else @(negedge clk);
    end
    edge_fall_i = fall;
    while (done_o) begin done_cycles++; @(negedge clk); end
    check("R10 done one cycle", done_cycles, 1);
    check("R1 first write value", first_mrw, 16'h0004);
    check("R1 first write select", first_sel, 3);
    check("R1 no read before pattern write", read_before_mrw, 0);
    check("R2 last write value", last_val, 0);
    check("R2 two writes per run", mrw, 2);
    check("R5 read count", reads, MAX_CODE + 1);
    check("R5 code per step", step_bad, 0);
    check("R9 request held", hold_bad, 0);
    check("R8 settle gap", settle_bad, 0);
    repeat (3) @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      int a = exp_low(l), b = exp_high(l);
      int ex = (a < 0) ? DEF_CODE : a + (b - a) / 2;
      check(a < 0 ? "R7 default code" : "R6 lane midpoint", code_of(l), ex);
      check("R7 lane error flag", int'(lane_err_o[l]), a < 0 ? 1 : 0);
    end
    check("R10 no restart after done", int'(cmd_req_o), 0);
  endtask

  task automatic set_win(int l, int a, int b, int s);
    lo[l] = a; hi[l] = b; spk[l] = s;
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check("R11 done at reset", int'(done_o), 0);
    check("R11 no request at reset", int'(cmd_req_o), 0);
    check("R11 lane0 code", code_of(0), DEF_CODE);
    check("R11 lane1 code", code_of(1), DEF_CODE);
    check("R11 error flags", int'(lane_err_o), 0);
    rst_n = 1;
    @(negedge clk);
    // R3 rising edge, R6 truncation on odd sum
    set_win(0, 10, 21, -1); set_win(1, 1, 64, -1); run_cal(0, 0);
    // R3 falling edge, R4 single bit corruption outside window
    set_win(0, 64, 127, -1); set_win(1, 30, 90, -1); run_cal(1, 0);
    // R7 lane 0 never passes, R6 lane 1 at code 0 only
    set_win(0, 200, 300, -1); set_win(1, 0, 0, -1); run_cal(0, 0);
    // window at top end and past MAX_CODE
    set_win(0, 127, 127, -1); set_win(1, 100, 200, -1); run_cal(1, 0);
    // isolated pass spike plus window, R6 lowest/highest
    set_win(0, 50, 60, 5); set_win(1, 20, 25, 120); run_cal(0, 0);
    // R10 start and R3 edge toggle during sweep are ignored
    set_win(0, 33, 77, -1); set_win(1, 8, 9, -1); run_cal(1, 1);
    // both lanes fail, R7
    set_win(0, -5, -1, -1); set_win(1, 130, 140, -1); run_cal(1, 0);
    for (int r = 0; r < 8; r++) begin
      for (int l = 0; l < LANES; l++) begin
        int a = $urandom_range(0, 140);
        int w = $urandom_range(0, 80);
        set_win(l, a, a + w, ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 127)) : -1);
      end
      run_cal(r[0], r == 3);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule